// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one starting column address into the ordered list of column addresses that a single read or write burst visits. The controller hands it a start request carrying the column address. Two configuration pins travel with that request: the burst length (four or eight beats) and the ordering (linear or interleaved). The block then emits one beat address per accepted output transfer until the burst is done. Reads and writes share the same ordering.

The beat addresses never leave the aligned block that the start address selects. With four beats, that block is four columns wide and bits 2 and up stay constant. With eight beats, it is eight columns wide and bits 3 and up stay constant. Only the low bits move, and they wrap around instead of carrying. Linear eight-beat bursts are nibble-based: the low two bits count modulo 4 inside the starting half of the block, and then bit 2 flips for the second half.

Both edges are valid/ready. The start side is ready when the block is idle, or when the final beat of the current burst is being handed off in the same cycle. A start request is accepted only on a cycle where start_valid and start_ready are both high. The output side holds beat_col and beat_last steady while beat_valid is high and beat_ready is low. A beat is consumed only on a cycle where beat_valid and beat_ready are both high.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beat_valid is low and start_ready is high.
- R2: The first beat of every burst carries exactly the accepted start column.
- R3: In four-beat linear mode (cfg_bl8=0, cfg_interleave=0), beat i has low two bits equal to (start[1:0] + i) mod 4, and bit 2 is unchanged.
- R4: In eight-beat linear mode (cfg_bl8=1, cfg_interleave=0), the low two bits of beat i are (start[1:0] + i) mod 4. Bit 2 equals start[2] for beats 0-3 and its inverse for beats 4-7. Example: from 6 the order is 6,7,4,5,2,3,0,1.
- R5: In interleaved mode (cfg_interleave=1), the low bits of beat i are the start low bits XOR i. This uses bits 1:0 for four beats and bits 2:0 for eight beats.
- R6: The column bits above the block stay equal to the start column for every beat. That is bits 2 and up for four beats, and bits 3 and up for eight beats.
- R7: A burst has exactly 4 beats when cfg_bl8=0 and exactly 8 beats when cfg_bl8=1. beat_last is high on the final beat only.
- R8: While beat_valid is high and beat_ready is low, beat_col and beat_last hold their values and beat_valid stays high.
- R9: During a burst, start_ready is low except on the final-beat hand-off. A start request, column or configuration presented then has no effect on the running burst.
- R10: A start presented on the same cycle that the final beat is handed off is accepted. Its first beat appears on the next cycle with no idle gap.
- R11: Burst length and ordering are sampled when the start request is accepted. They are held for the whole burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start request present |
| start_ready | output | 1 | Start request can be accepted this cycle |
| start_col | input | COL_W | Starting column address |
| cfg_bl8 | input | 1 | 1 = eight-beat burst, 0 = four-beat burst |
| cfg_interleave | input | 1 | 1 = interleaved order, 0 = linear (nibble-based) order |
| beat_valid | output | 1 | Beat address present |
| beat_ready | input | 1 | Consumer accepts the beat |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one of the burst |

## Verification
The final-beat hand-off and the acceptance of a new start request can fall in the same cycle. The bench provokes this by holding start_valid high with a fresh column and configuration while the last beat is consumed. It then checks that start_ready is high in that cycle and that the next cycle already shows the new burst's first address. This is checked under the new configuration, not the old one. Separately, the bench presents start requests during the body of a burst with altered columns and configuration. It judges through the beat stream that they changed nothing.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int unsigned IDX_W = 3;

  typedef struct packed {
    logic bl8;
    logic ilv;
  } burst_cfg_t;
endpackage

// File: rtl/burst_order.sv
module burst_order
  import bseq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [IDX_W-1:0] idx,
  input  burst_cfg_t       cfg,
  output logic [COL_W-1:0] col
);
  logic [1:0] low2;
  logic       bit2;

  always_comb begin
    if (cfg.ilv) low2 = base[1:0] ^ idx[1:0];
    else         low2 = base[1:0] + idx[1:0];
    bit2 = base[2] ^ (cfg.bl8 & idx[2]);
  end

  if (COL_W > IDX_W) begin : g_upper
    assign col = {base[COL_W-1:IDX_W], bit2, low2};
  end else begin : g_narrow
    assign col = {bit2, low2};
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter
  import bseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic             bl8,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             last
);
  logic [IDX_W-1:0] final_idx;

  assign final_idx = bl8 ? IDX_W'(7) : IDX_W'(3);
  assign last      = busy && (idx == final_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy || (advance && last)) begin
      busy <= load;
      idx  <= '0;
    end else if (advance) begin
      idx <= idx + IDX_W'(1);
    end
  end

  assert_short_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bl8) |-> (idx <= IDX_W'(3)));
  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && busy && !last) |=> (busy && idx == $past(idx) + IDX_W'(1)));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bseq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [COL_W-1:0] start_col,
  input  logic             cfg_bl8,
  input  logic             cfg_interleave,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last
);
  logic [COL_W-1:0] base_q;
  burst_cfg_t       cfg_q;
  logic [IDX_W-1:0] idx;
  logic             busy, last, load, advance;

  assign advance     = busy && beat_ready;
  assign start_ready = !busy || (last && beat_ready);
  assign load        = start_valid && start_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cfg_q  <= '0;
    end else if (load) begin
      base_q <= start_col;
      cfg_q  <= '{bl8: cfg_bl8, ilv: cfg_interleave};
    end
  end

  beat_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .bl8(cfg_q.bl8), .idx(idx), .busy(busy), .last(last)
  );

  burst_order #(.COL_W(COL_W)) u_ord (
    .base(base_q), .idx(idx), .cfg(cfg_q), .col(beat_col)
  );

  assign beat_valid = busy;
  assign beat_last  = last;

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> (beat_valid && beat_col == $past(start_col)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_col) && $stable(beat_last)));
  assert_block_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !beat_last) |=>
      (beat_col[COL_W-1:3] == $past(beat_col[COL_W-1:3])));
  assert_no_start_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !(beat_last && beat_ready)) |-> !start_ready);
  assert_idle_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last && !start_valid) |=> !beat_valid);
endmodule

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  localparam int COL_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_valid = 1'b0, cfg_bl8 = 1'b0, cfg_interleave = 1'b0, beat_ready = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic start_ready, beat_valid, beat_last;
  logic [COL_W-1:0] beat_col;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut (.*);

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(input int s, input int i, input bit bl8, input bit ilv);
    int low, hi, lo;
    hi  = s & ~7;
    low = s & 7;
    if (ilv) lo = bl8 ? (low ^ i) : ((low & 4) | ((low ^ i) & 3));
    else if (bl8) lo = ((i < 4) ? (low & 4) : ((low & 4) ^ 4)) | (((low & 3) + i) % 4);
    else lo = (low & 4) | (((low & 3) + i) % 4);
    return hi | lo;
  endfunction

  // Runs one burst; a start was accepted at the last posedge. If chain, a new
  // start (nc, nb, ni) is presented during the final-beat hand-off.
  task automatic run_burst(input int s, input bit bl8, input bit ilv, input int seed,
                           input bit chain, input int nc, input bit nb, input bit ni);
    int n = bl8 ? 8 : 4;
    string rq;
    for (int i = 0; i < n; i++) begin
      rq = ilv ? "R5" : (bl8 ? "R4" : "R3");
      for (int st = 0; st < ((seed + i) % 3); st++) begin
        @(negedge clk);
        beat_ready = 1'b0;
        start_valid = 1'b1; start_col = COL_W'(s ^ 10'h2A5);  // R9 intruder
        cfg_bl8 = ~bl8; cfg_interleave = ~ilv;
        #1;
        check("R8 valid held", int'(beat_valid), 1);
        check("R8 col held", int'(beat_col), exp_col(s, i, bl8, ilv));
        check("R9 start blocked", int'(start_ready), 0);
      end
      @(negedge clk);
      beat_ready = 1'b1;
      if (i == n - 1 && chain) begin
        start_valid = 1'b1; start_col = COL_W'(nc); cfg_bl8 = nb; cfg_interleave = ni;
      end else begin
        start_valid = (i != n - 1);
        start_col = COL_W'(s ^ 10'h155); cfg_bl8 = ~bl8; cfg_interleave = ~ilv;
      end
      #1;
      check(i == 0 ? "R2 first beat" : rq, int'(beat_col), exp_col(s, i, bl8, ilv));
      check("R6 block bits", int'(beat_col) >> (bl8 ? 3 : 2), s >> (bl8 ? 3 : 2));
      check("R7 last flag", int'(beat_last), int'(i == n - 1));
      check("R7 valid", int'(beat_valid), 1);
      check(i == n - 1 ? "R10 ready on hand-off" : "R9 ready low",
            int'(start_ready), int'(i == n - 1));
    end
    @(negedge clk);
    start_valid = 1'b0; beat_ready = 1'b0;
    #1;
    if (!chain) check("R7 burst ended", int'(beat_valid), 0);
    else check("R10 no gap", int'(beat_col), nc);
  endtask

  task automatic launch(input int s, input bit bl8, input bit ilv);
    @(negedge clk);
    start_valid = 1'b1; start_col = COL_W'(s); cfg_bl8 = bl8; cfg_interleave = ilv;
    beat_ready = 1'b0;
    #1;
    check("R1 idle start_ready", int'(start_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 reset valid", int'(beat_valid), 0);
    check("R1 reset start_ready", int'(start_ready), 1);
    rst_n = 1'b1;
    for (int bl = 0; bl < 2; bl++)
      for (int il = 0; il < 2; il++)
        for (int up = 0; up < 3; up++)
          for (int lo = 0; lo < 8; lo++) begin
            int s = (up * 341 + lo) & 10'h3FF;
            launch(s, bl[0], il[0]);
            run_burst(s, bl[0], il[0], lo + up, 1'b0, 0, 1'b0, 1'b0);
          end
    // R10 / R11: back-to-back chain across changing configurations
    launch(10'h3F6, 1'b1, 1'b0);
    run_burst(10'h3F6, 1'b1, 1'b0, 1, 1'b1, 10'h101, 1'b0, 1'b1);
    run_burst(10'h101, 1'b0, 1'b1, 0, 1'b1, 10'h0C5, 1'b1, 1'b1);
    run_burst(10'h0C5, 1'b1, 1'b1, 2, 1'b0, 0, 1'b0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule